// File: doc/BRIEF.md
# Errored Second Performance Classifier

This block grades each one-second interval of a line-monitoring path. A single-cycle strobe marks each errored event (a framing-bit error, a CRC error or a similar defect). A saturating counter counts these strobes between one-second ticks. When the tick arrives, the block compares the accumulated count against two programmable limits. It then marks the finished second as errored, severely errored or bursty errored.

The grade is registered together with a one-cycle valid pulse. Three saturating totals keep a running tally of how many seconds earned each grade. A two-bit mode input decides whether bursty grading happens at all. When it is enabled, a bursty second is one whose count lies above the errored limit but not above the severe limit. Severe grading takes priority in that case. Counters, flags and the valid pulse all clear on reset.

Top module: `err_sec_classifier`

## Requirements
- R1: The event counter adds one for each cycle with `err_evt` high and sticks at all ones (2^CNT_W-1) instead of wrapping.
- R2: `es_flag` is 1 for a graded second exactly when its event count is strictly greater than `es_thresh`.
- R3: `ses_flag` is 1 for a graded second exactly when its event count is strictly greater than `ses_thresh`.
- R4: `bes_flag` can be 1 only when `bes_mode` is 2'b01 at the tick. In that mode it is 1 when the count exceeds `es_thresh` and does not exceed `ses_thresh`. The mode values 2'b00, 2'b10 and 2'b11 force it to 0, and it is never 1 together with `ses_flag`.
- R5: On the cycle the tick is sampled, the counter restarts. An event strobe in that same cycle is counted in the new interval, not the one being graded.
- R6: `grade_valid` is high for exactly the one cycle after each cycle in which `sec_tick` is sampled high. The three flags change only at those cycles and hold their value in between.
- R7: `es_total`, `ses_total` and `bes_total` each increase by one for every graded second whose matching flag is set. Each saturates at 2^TOT_W-1.
- R8: After reset the flags, `grade_valid`, the event count and all totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 1 | One-cycle errored event strobe |
| sec_tick | input | 1 | One-cycle end-of-second marker |
| es_thresh | input | ES_THR_W (8) | Errored second limit |
| ses_thresh | input | SES_THR_W (16) | Severely errored second limit |
| bes_mode | input | 2 | Bursty grading mode, 2'b01 enables |
| es_flag | output | 1 | Last graded second was errored |
| ses_flag | output | 1 | Last graded second was severely errored |
| bes_flag | output | 1 | Last graded second was bursty errored |
| grade_valid | output | 1 | Pulse marking a fresh grade |
| es_total | output | TOT_W (16) | Count of errored seconds |
| ses_total | output | TOT_W (16) | Count of severely errored seconds |
| bes_total | output | TOT_W (16) | Count of bursty errored seconds |

## Verification
The assertions assume that `sec_tick` and `err_evt` are clean single-cycle strobes that are known after reset. They also assume the limits and mode are stable in the cycle the tick is sampled, since the grade is taken from them at that edge. The stimulus drives every input on the falling clock edge and changes the limits and mode only between seconds. Each tick is followed by a quiet cycle, so the valid pulse can be observed falling before the next interval's events start.

// File: rtl/esc_pkg.sv
package esc_pkg;
   typedef enum logic [1:0] {
      BES_OFF_A = 2'b00,
      BES_BAND  = 2'b01,
      BES_OFF_B = 2'b10,
      BES_OFF_C = 2'b11
   } bes_mode_e;

   localparam int unsigned GRADE_N = 3;
   localparam int unsigned G_ES  = 0;
   localparam int unsigned G_SES = 1;
   localparam int unsigned G_BES = 2;
endpackage

// File: rtl/esc_event_counter.sv
module esc_event_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (tick)
         count <= evt ? CNT_W'(1) : '0;
      else if (evt && count != CNT_MAX)
         count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/esc_grader.sv
module esc_grader
   import esc_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ES_THR_W  = 8,
   parameter int unsigned SES_THR_W = 16
) (
   input  logic [CNT_W-1:0]     count,
   input  logic [ES_THR_W-1:0]  es_lim,
   input  logic [SES_THR_W-1:0] ses_lim,
   input  logic [1:0]           mode,
   output logic [GRADE_N-1:0]   grade
);
   localparam int unsigned CMP_W =
      (CNT_W > ES_THR_W) ? ((CNT_W > SES_THR_W) ? CNT_W : SES_THR_W)
                         : ((ES_THR_W > SES_THR_W) ? ES_THR_W : SES_THR_W);

   logic [CMP_W-1:0] cnt_x, es_x, ses_x;
   logic             over_es, over_ses;

   always_comb begin
      cnt_x    = CMP_W'(count);
      es_x     = CMP_W'(es_lim);
      ses_x    = CMP_W'(ses_lim);
      over_es  = cnt_x > es_x;
      over_ses = cnt_x > ses_x;
      grade[G_ES]  = over_es;
      grade[G_SES] = over_ses;
      grade[G_BES] = (bes_mode_e'(mode) == BES_BAND) && over_es && !over_ses;
   end
endmodule

// File: rtl/esc_tally.sv
module esc_tally #(
   parameter int unsigned TOT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [TOT_W-1:0] total
);
   localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)
         total <= '0;
      else if (inc && total != TOT_MAX)
         total <= total + TOT_W'(1);
   end
endmodule

// File: rtl/err_sec_classifier.sv
module err_sec_classifier
   import esc_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ES_THR_W  = 8,
   parameter int unsigned SES_THR_W = 16,
   parameter int unsigned TOT_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 err_evt,
   input  logic                 sec_tick,
   input  logic [ES_THR_W-1:0]  es_thresh,
   input  logic [SES_THR_W-1:0] ses_thresh,
   input  logic [1:0]           bes_mode,
   output logic                 es_flag,
   output logic                 ses_flag,
   output logic                 bes_flag,
   output logic                 grade_valid,
   output logic [TOT_W-1:0]     es_total,
   output logic [TOT_W-1:0]     ses_total,
   output logic [TOT_W-1:0]     bes_total
);
   generate
      if (CNT_W < 1 || CNT_W > 32)
         $error("CNT_W must lie in 1..32");
      if (ES_THR_W < 1 || SES_THR_W < 1)
         $error("threshold widths must be positive");
      if (TOT_W < 1 || TOT_W > 32)
         $error("TOT_W must lie in 1..32");
   endgenerate

   logic [CNT_W-1:0]   evt_count;
   logic [GRADE_N-1:0] grade_now;
   logic [GRADE_N-1:0] grade_q;
   logic               valid_q;
   logic [TOT_W-1:0]   totals [GRADE_N];

   esc_event_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (err_evt),
      .tick  (sec_tick),
      .count (evt_count)
   );

   esc_grader #(
      .CNT_W     (CNT_W),
      .ES_THR_W  (ES_THR_W),
      .SES_THR_W (SES_THR_W)
   ) u_grade (
      .count   (evt_count),
      .es_lim  (es_thresh),
      .ses_lim (ses_thresh),
      .mode    (bes_mode),
      .grade   (grade_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grade_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= sec_tick;
         if (sec_tick)
            grade_q <= grade_now;
      end
   end

   for (genvar g = 0; g < GRADE_N; g++) begin : g_tally
      esc_tally #(.TOT_W(TOT_W)) u_tally (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (sec_tick & grade_now[g]),
         .total (totals[g])
      );
   end

   assign es_flag     = grade_q[G_ES];
   assign ses_flag    = grade_q[G_SES];
   assign bes_flag    = grade_q[G_BES];
   assign grade_valid = valid_q;
   assign es_total    = totals[G_ES];
   assign ses_total   = totals[G_SES];
   assign bes_total   = totals[G_BES];
endmodule

// File: rtl/esc_checker.sv
module esc_checker #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ES_THR_W  = 8,
   parameter int unsigned SES_THR_W = 16,
   parameter int unsigned TOT_W     = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sec_tick,
   input logic                 err_evt,
   input logic [ES_THR_W-1:0]  es_thresh,
   input logic [SES_THR_W-1:0] ses_thresh,
   input logic [1:0]           bes_mode,
   input logic [CNT_W-1:0]     evt_count,
   input logic                 es_flag,
   input logic                 ses_flag,
   input logic                 bes_flag,
   input logic                 grade_valid,
   input logic [TOT_W-1:0]     es_total,
   input logic [TOT_W-1:0]     ses_total
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};

   a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_count == CNT_MAX && !sec_tick) |=> evt_count == CNT_MAX);

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && err_evt && evt_count != CNT_MAX) |=> evt_count == $past(evt_count) + CNT_W'(1));

   a_r2_es_grade: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> es_flag == ($past(evt_count) > $past(es_thresh)));

   a_r3_ses_grade: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> ses_flag == ($past(evt_count) > $past(ses_thresh)));

   a_r4_bes_excl: assert property (@(posedge clk) disable iff (!rst_n)
      bes_flag |-> (es_flag && !ses_flag));

   a_r4_bes_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && bes_mode != 2'b01) |=> !bes_flag);

   a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> evt_count == CNT_W'($past(err_evt)));

   a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> grade_valid);

   a_r6_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick |=> !grade_valid);

   a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !grade_valid |-> ($stable(es_flag) && $stable(ses_flag) && $stable(bes_flag)));

   a_r7_es_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (grade_valid && es_flag && $past(es_total) != TOT_MAX) |-> es_total == $past(es_total) + TOT_W'(1));

   a_r7_ses_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !grade_valid |-> $stable(ses_total));
endmodule

bind err_sec_classifier esc_checker #(
   .CNT_W     (CNT_W),
   .ES_THR_W  (ES_THR_W),
   .SES_THR_W (SES_THR_W),
   .TOT_W     (TOT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_tick    (sec_tick),
   .err_evt     (err_evt),
   .es_thresh   (es_thresh),
   .ses_thresh  (ses_thresh),
   .bes_mode    (bes_mode),
   .evt_count   (evt_count),
   .es_flag     (es_flag),
   .ses_flag    (ses_flag),
   .bes_flag    (bes_flag),
   .grade_valid (grade_valid),
   .es_total    (es_total),
   .ses_total   (ses_total)
);

// File: tb/err_sec_classifier_test.sv
module err_sec_classifier_test;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 4;
   localparam int TOT_W      = 3;
   localparam int CNT_MAX    = (1 << CNT_W) - 1;
   localparam int TOT_MAX    = (1 << TOT_W) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_evt = 1'b0;
   logic        sec_tick = 1'b0;
   logic [7:0]  es_thresh = '0;
   logic [15:0] ses_thresh = '0;
   logic [1:0]  bes_mode = '0;
   logic        es_flag, ses_flag, bes_flag, grade_valid;
   logic [TOT_W-1:0] es_total, ses_total, bes_total;

   int n_tests = 0;
   int n_fail  = 0;
   int m_cnt   = 0;
   int m_es = 0, m_ses = 0, m_bes = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   err_sec_classifier #(.CNT_W(CNT_W), .ES_THR_W(8), .SES_THR_W(16), .TOT_W(TOT_W)) uut (
      .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .sec_tick(sec_tick),
      .es_thresh(es_thresh), .ses_thresh(ses_thresh), .bes_mode(bes_mode),
      .es_flag(es_flag), .ses_flag(ses_flag), .bes_flag(bes_flag),
      .grade_valid(grade_valid), .es_total(es_total), .ses_total(ses_total),
      .bes_total(bes_total)
   );

   task automatic chk(input string rq, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // One second with n events, optional event on the tick cycle.
   task automatic run_second(input int n, input bit coin, input int est,
                             input int sest, input int mode, input string tag);
      int c;
      bit e_es, e_ses, e_bes;
      @(negedge clk);
      es_thresh = 8'(est); ses_thresh = 16'(sest); bes_mode = 2'(mode);
      for (int i = 0; i < n; i++) begin
         err_evt = 1'b1;
         @(negedge clk);
      end
      err_evt = coin; sec_tick = 1'b1;
      @(negedge clk);
      err_evt = 1'b0; sec_tick = 1'b0;
      c = m_cnt + n;
      if (c > CNT_MAX) c = CNT_MAX;
      e_es  = c > est;
      e_ses = c > sest;
      e_bes = (mode == 1) && e_es && !e_ses;
      if (e_es  && m_es  < TOT_MAX) m_es++;
      if (e_ses && m_ses < TOT_MAX) m_ses++;
      if (e_bes && m_bes < TOT_MAX) m_bes++;
      m_cnt = coin ? 1 : 0;
      chk({tag, " R6 valid high"}, int'(grade_valid), 1);
      chk({tag, " R2 es"}, int'(es_flag), int'(e_es));
      chk({tag, " R3 ses"}, int'(ses_flag), int'(e_ses));
      chk({tag, " R4 bes"}, int'(bes_flag), int'(e_bes));
      chk({tag, " R7 es_total"}, int'(es_total), m_es);
      chk({tag, " R7 ses_total"}, int'(ses_total), m_ses);
      chk({tag, " R7 bes_total"}, int'(bes_total), m_bes);
      @(negedge clk);
      chk({tag, " R6 valid low"}, int'(grade_valid), 0);
      chk({tag, " R6 es hold"}, int'(es_flag), int'(e_es));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset valid", int'(grade_valid), 0);
      chk("R8 reset flags", int'({es_flag, ses_flag, bes_flag}), 0);
      chk("R8 reset totals", int'({es_total, ses_total, bes_total}), 0);

      // R8: empty second after reset grades clean with zero limits.
      run_second(0, 0, 0, 0, 1, "R8 empty");
      // R1: 20 events saturate at 15: 15 > 14 but not > 15.
      run_second(20, 0, 14, 15, 0, "R1 sat");
      // R5: event on tick starts next second at 1; then 0 new events, limit 0.
      run_second(2, 1, 7, 7, 1, "R5 coin");
      run_second(0, 0, 0, 9, 1, "R5 carried");
      chk("R5 carried event graded es", int'(es_flag), 1);
      // R4: band case, then the same count with other modes.
      run_second(5, 0, 3, 8, 1, "R4 band");
      run_second(5, 0, 3, 8, 2, "R4 mode10");
      run_second(5, 0, 3, 8, 3, "R4 mode11");

      for (int mode = 0; mode < 4; mode++)
         for (int est = 0; est < 16; est += 5)
            for (int sest = 1; sest < 17; sest += 5)
               for (int n = 0; n < 18; n += 2)
                  run_second(n, bit'((n / 2) % 2), est, sest, mode, "sweep");
      done = 1;
      report();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         report();
      end
   end
endmodule